// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into a physical page number when the translation cache in front of it misses. It walks a sparse two-level table held in a word-addressed memory. A base address names the first-level table. Software may point that base at a different table for each process. The walker samples the base together with each request.

The upper part of the virtual page number indexes the first-level table. When that entry is valid, it points at a second-level table, and the lower part of the page number indexes that table. The leaf entry supplies the physical page number and its access rights. A first-level entry with a clear valid bit has no second-level table behind it, so the walk stops there with a fault and makes no second read. A leaf with a clear valid bit means the page is not resident and also ends in a fault.

Only one walk is in flight at a time. The memory port accepts one-cycle read strobes and returns data after any number of cycles. The result is presented for exactly one cycle.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous reset the walker is idle: `reqReady` is 1, and `rspValid` and `memReqValid` are 0.
- R2: `reqReady` is 1 only while idle. It is 0 whenever a memory read is issued or a response is presented.
- R3: The first read of a walk goes to word address `ptBase + reqVpn[7:4]`, where `ptBase` is the value sampled when the request is accepted. Each entry occupies one word.
- R4: Entry layout: bit 0 is the valid flag, bits [2:1] are access rights, and bits [15:4] hold the next-table word address (first level) or the physical page number (leaf).
- R5: A first-level entry with bit 0 clear ends the walk after exactly one read, with status 1 (first-level fault) and zero page number and rights.
- R6: A valid first-level entry causes a second read at word address `entry[15:4] + reqVpn[3:0]`. No walk issues more than two reads.
- R7: A leaf with bit 0 clear ends the walk with status 2 (second-level fault) and zero page number and rights.
- R8: A valid leaf ends the walk with status 0 and returns `entry[15:4]` on `rspPpn` and `entry[2:1]` on `rspRights` (0 read-only, 1 read/write, 2 executable).
- R9: `rspValid` is high for exactly one cycle per accepted request.
- R10: Changing `ptBase` between walks selects a different first-level table. Changing it during a walk has no effect on that walk.
- R11: The walker waits any number of cycles for `memRspValid`. Each read strobe `memReqValid` lasts one cycle.
- R12: `reqValid` and `reqVpn` are ignored while a walk is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Walker idle, request accepted |
| reqVpn | input | 8 | Virtual page number |
| ptBase | input | 12 | First-level table word address |
| memReqValid | output | 1 | One-cycle read strobe |
| memReqAddr | output | 12 | Read word address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 16 | Read data (table entry) |
| rspValid | output | 1 | One-cycle result strobe |
| rspStatus | output | 2 | 0 ok, 1 first-level fault, 2 second-level fault |
| rspPpn | output | 12 | Physical page number |
| rspRights | output | 2 | Access rights |

## Verification
Every one of the 256 page numbers is walked against two arithmetically generated tables, one for each base. In each table, some first-level slots and some leaves are invalid, so the sweep separates early first-level faults from leaf faults and from good translations. The memory latency cycles from zero to seven cycles, which shows that the result does not depend on response timing. On a subset of walks, the request and base inputs are scrambled while the walk runs; these walks tell a walker that samples its inputs once apart from one that reads them live.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    IDLE, READ_L1, WAIT_L1, READ_L2, WAIT_L2, DONE
  } walkState_e;

  typedef enum logic [1:0] {
    ST_OK = 2'd0, ST_FAULT_L1 = 2'd1, ST_FAULT_L2 = 2'd2
  } walkStatus_e;

  typedef struct packed {
    logic capReq;
    logic memRd;
    logic selL2;
    logic capL1;
    logic capFault1;
    logic capLeaf;
    logic rspOut;
  } walkCtrl_t;
endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  input  logic      memRspValid,
  input  logic      entryValid,
  output logic      reqReady,
  output walkCtrl_t strobes
);
  walkState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    reqReady  = 1'b0;
    case (state)
      IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobes.capReq = 1'b1;
          stateNext = READ_L1;
        end
      end
      READ_L1: begin
        strobes.memRd = 1'b1;
        stateNext = WAIT_L1;
      end
      WAIT_L1: begin
        if (memRspValid) begin
          if (entryValid) begin
            strobes.capL1 = 1'b1;
            stateNext = READ_L2;
          end else begin
            strobes.capFault1 = 1'b1;
            stateNext = DONE;
          end
        end
      end
      READ_L2: begin
        strobes.memRd = 1'b1;
        strobes.selL2 = 1'b1;
        stateNext = WAIT_L2;
      end
      WAIT_L2: begin
        if (memRspValid) begin
          strobes.capLeaf = 1'b1;
          stateNext = DONE;
        end
      end
      DONE: begin
        strobes.rspOut = 1'b1;
        stateNext = IDLE;
      end
      default: stateNext = IDLE;
    endcase
  end
endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int L1_IDX_W = 4,
  parameter int L2_IDX_W = 4,
  parameter int ADDR_W   = 12,
  parameter int PPN_W    = 12,
  parameter int ENTRY_W  = 16,
  parameter int RIGHTS_W = 2,
  localparam int VPN_W   = L1_IDX_W + L2_IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  walkCtrl_t           strobes,
  input  logic [VPN_W-1:0]    reqVpn,
  input  logic [ADDR_W-1:0]   ptBase,
  input  logic [ENTRY_W-1:0]  memRspData,
  output logic                entryValid,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [1:0]          rspStatus,
  output logic [PPN_W-1:0]    rspPpn,
  output logic [RIGHTS_W-1:0] rspRights
);
  logic [VPN_W-1:0]    vpnQ;
  logic [ADDR_W-1:0]   baseQ;
  logic [ADDR_W-1:0]   ptrQ;
  logic [PPN_W-1:0]    ppnQ;
  logic [RIGHTS_W-1:0] rightsQ;
  walkStatus_e         statusQ;

  logic [PPN_W-1:0]    entryFrame;
  logic [RIGHTS_W-1:0] entryRights;
  logic [ADDR_W-1:0]   entryPtr;

  assign entryValid  = memRspData[0];
  assign entryRights = memRspData[RIGHTS_W:1];
  assign entryFrame  = memRspData[ENTRY_W-1 -: PPN_W];

  generate
    if (ADDR_W <= PPN_W) begin : g_ptrNarrow
      assign entryPtr = entryFrame[ADDR_W-1:0];
    end else begin : g_ptrWide
      assign entryPtr = ADDR_W'(entryFrame);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vpnQ    <= '0;
      baseQ   <= '0;
      ptrQ    <= '0;
      ppnQ    <= '0;
      rightsQ <= '0;
      statusQ <= ST_OK;
    end else begin
      if (strobes.capReq) begin
        vpnQ    <= reqVpn;
        baseQ   <= ptBase;
        ppnQ    <= '0;
        rightsQ <= '0;
        statusQ <= ST_OK;
      end
      if (strobes.capL1)     ptrQ <= entryPtr;
      if (strobes.capFault1) statusQ <= ST_FAULT_L1;
      if (strobes.capLeaf) begin
        if (entryValid) begin
          ppnQ    <= entryFrame;
          rightsQ <= entryRights;
        end else begin
          statusQ <= ST_FAULT_L2;
        end
      end
    end
  end

  logic [L1_IDX_W-1:0] idxL1;
  logic [L2_IDX_W-1:0] idxL2;
  assign idxL1 = vpnQ[VPN_W-1 -: L1_IDX_W];
  assign idxL2 = vpnQ[L2_IDX_W-1:0];

  assign memReqAddr = strobes.selL2 ? ptrQ + ADDR_W'(idxL2)
                                    : baseQ + ADDR_W'(idxL1);
  assign rspStatus  = statusQ;
  assign rspPpn     = ppnQ;
  assign rspRights  = rightsQ;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int L1_IDX_W = 4,
  parameter int L2_IDX_W = 4,
  parameter int ADDR_W   = 12,
  parameter int PPN_W    = 12,
  parameter int ENTRY_W  = 16,
  parameter int RIGHTS_W = 2,
  localparam int VPN_W   = L1_IDX_W + L2_IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [VPN_W-1:0]    reqVpn,
  input  logic [ADDR_W-1:0]   ptBase,
  output logic                memReqValid,
  output logic [ADDR_W-1:0]   memReqAddr,
  input  logic                memRspValid,
  input  logic [ENTRY_W-1:0]  memRspData,
  output logic                rspValid,
  output logic [1:0]          rspStatus,
  output logic [PPN_W-1:0]    rspPpn,
  output logic [RIGHTS_W-1:0] rspRights
);
  walkCtrl_t strobes;
  logic      entryValid;

  pt_walker_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .memRspValid(memRspValid),
    .entryValid(entryValid), .reqReady(reqReady), .strobes(strobes)
  );

  pt_walker_dp #(
    .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W), .ADDR_W(ADDR_W),
    .PPN_W(PPN_W), .ENTRY_W(ENTRY_W), .RIGHTS_W(RIGHTS_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .reqVpn(reqVpn), .ptBase(ptBase),
    .memRspData(memRspData), .entryValid(entryValid), .memReqAddr(memReqAddr),
    .rspStatus(rspStatus), .rspPpn(rspPpn), .rspRights(rspRights)
  );

  assign memReqValid = strobes.memRd;
  assign rspValid    = strobes.rspOut;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PPN_W    = 12,
  parameter int RIGHTS_W = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                reqValid,
  input logic                reqReady,
  input logic                memReqValid,
  input logic                rspValid,
  input logic [1:0]          rspStatus,
  input logic [PPN_W-1:0]    rspPpn,
  input logic [RIGHTS_W-1:0] rspRights
);
  logic [1:0] rdCnt;

  always_ff @(posedge clk) begin
    if (rst)                       rdCnt <= '0;
    else if (reqValid && reqReady) rdCnt <= '0;
    else if (memReqValid)          rdCnt <= rdCnt + 2'd1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reqReady && !rspValid && !memReqValid));

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (memReqValid || rspValid) |-> !reqReady);

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspStatus != 2'd0) |-> (rspPpn == '0 && rspRights == '0));

  assert_two_reads_R6: assert property (@(posedge clk) disable iff (rst)
    memReqValid |-> (rdCnt < 2'd2));

  assert_status_legal_R8: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> (rspStatus != 2'd3));

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);

  assert_memreq_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    memReqValid |=> !memReqValid);
endmodule

bind pt_walker pt_walker_chk #(.PPN_W(PPN_W), .RIGHTS_W(RIGHTS_W)) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .memReqValid(memReqValid), .rspValid(rspValid), .rspStatus(rspStatus),
  .rspPpn(rspPpn), .rspRights(rspRights)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        reqValid = 0;
  logic        reqReady;
  logic [7:0]  reqVpn = '0;
  logic [11:0] ptBase = '0;
  logic        memReqValid;
  logic [11:0] memReqAddr;
  logic        memRspValid = 0;
  logic [15:0] memRspData = '0;
  logic        rspValid;
  logic [1:0]  rspStatus;
  logic [11:0] rspPpn;
  logic [1:0]  rspRights;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqVpn(reqVpn), .ptBase(ptBase), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspStatus(rspStatus), .rspPpn(rspPpn),
    .rspRights(rspRights)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] baseOf(input int variant);
    return (variant != 0) ? 12'h040 : 12'h020;
  endfunction

  // table model: first-level slot k points to 0x100 + 16*k
  function automatic logic [15:0] memData(input logic [11:0] addr, input int variant);
    int b, i, k, j, ppn, rt;
    b = int'(baseOf(variant));
    if (int'(addr) >= b && int'(addr) < b + 16) begin
      i = int'(addr) - b;
      k = (i + 5 * variant) % 16;
      return {12'(16'h100 + k * 16), 3'b000, (k % 4 != 1)};
    end else if (addr >= 12'h100 && addr < 12'h200) begin
      k   = (int'(addr) - 16'h100) / 16;
      j   = int'(addr) % 16;
      ppn = (k * 37 + j * 11 + 5) % 4096;
      rt  = (k + j) % 3;
      return {12'(ppn), 1'(j % 2), 2'(rt), ((k + j) % 5 != 2)};
    end
    return 16'hFFFE;
  endfunction

  task automatic walk(input logic [7:0] vpn, input int variant, input int lat,
                      input bit disturb);
    int i, j, k, nRd, expStatus, expPpn, expRt;
    bit done, skip, l1ok, l2ok;
    logic [11:0] rdAddr [2];
    i = int'(vpn[7:4]);
    j = int'(vpn[3:0]);
    k = (i + 5 * variant) % 16;
    l1ok = (k % 4 != 1);
    l2ok = ((k + j) % 5 != 2);
    expStatus = !l1ok ? 1 : (!l2ok ? 2 : 0);
    expPpn = (expStatus == 0) ? (k * 37 + j * 11 + 5) % 4096 : 0;
    expRt  = (expStatus == 0) ? (k + j) % 3 : 0;
    rdAddr[0] = '0; rdAddr[1] = '0;

    reqVpn = vpn; ptBase = baseOf(variant); reqValid = 1;
    @(negedge clk);
    if (disturb) begin
      reqVpn = ~vpn;           // R12: ignored while busy
      ptBase = 12'h7A5;        // R10: mid-walk change has no effect
    end else reqValid = 0;

    done = 0; nRd = 0; skip = 1;
    for (int c = 0; c < 80 && !done; c++) begin
      if (!skip) @(negedge clk);
      skip = 0;
      if (memReqValid) begin
        chk(reqReady == 0, "R2 ready while reading", reqReady, 0);
        if (nRd < 2) rdAddr[nRd] = memReqAddr;
        nRd++;
        @(negedge clk);
        chk(memReqValid == 0, "R11 read strobe width", memReqValid, 0);
        repeat (lat) @(negedge clk);
        memRspData  = memData(rdAddr[(nRd > 2) ? 1 : nRd - 1], variant);
        memRspValid = 1;
        @(negedge clk);
        memRspValid = 0;
        memRspData  = 16'hA5A5;
        skip = 1;
      end else if (rspValid) begin
        reqValid = 0;
        chk(reqReady == 0, "R2 ready during response", reqReady, 0);
        chk(int'(rdAddr[0]) == int'(baseOf(variant)) + i, "R3 first address",
            rdAddr[0], int'(baseOf(variant)) + i);
        if (!l1ok) begin
          chk(nRd == 1, "R5 single read on first-level fault", nRd, 1);
        end else begin
          chk(nRd == 2, "R6 two reads", nRd, 2);
          chk(int'(rdAddr[1]) == 16'h100 + k * 16 + j, "R6 second address",
              rdAddr[1], 16'h100 + k * 16 + j);
        end
        if (expStatus == 1)
          chk(rspStatus == 2'd1 && rspPpn == 0 && rspRights == 0,
              "R5 first-level fault", {rspStatus, rspPpn, rspRights}, 16'h4000);
        else if (expStatus == 2)
          chk(rspStatus == 2'd2 && rspPpn == 0 && rspRights == 0,
              "R7 leaf fault", {rspStatus, rspPpn, rspRights}, 16'h8000);
        else begin
          chk(rspStatus == 2'd0, "R8 ok status", rspStatus, 0);
          chk(int'(rspPpn) == expPpn && int'(rspRights) == expRt,
              "R4 R8 ppn/rights", {rspPpn, rspRights}, {12'(expPpn), 2'(expRt)});
        end
        if (disturb)
          chk(int'(rspStatus) == expStatus, "R10 R12 inputs ignored mid-walk",
              rspStatus, expStatus);
        @(negedge clk);
        chk(rspValid == 0, "R9 response width", rspValid, 0);
        chk(reqReady == 1, "R2 ready after walk", reqReady, 1);
        done = 1;
      end
    end
    reqValid = 0;
    if (!done) chk(0, "R9 no response", 0, 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(reqReady == 1 && rspValid == 0 && memReqValid == 0, "R1 reset state",
        {reqReady, rspValid, memReqValid}, 3'b100);
    for (int v = 0; v < 256; v++) walk(8'(v), 0, v % 4, 0);
    for (int v = 0; v < 256; v++) walk(8'(v), 1, (v * 3) % 8, (v % 3) == 0);
    for (int v = 0; v < 16; v++)  walk(8'(v * 17), 0, 7, 1);
    summary();
    $finish;
  end
endmodule